// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching translation entries from a two-level table kept in ordinary memory. A requester presents a virtual address together with a read/write flag and a user/supervisor flag. The walker forms the address of the first-level entry from a root-pointer register, fetches that entry over a single word-wide memory port, and then either fetches the second-level entry or, when the first-level entry maps a 4 MB region, stops there.

Every fetched entry is checked for presence before anything else, then for write and user permission. A walk either returns a physical address or a fault with a two-bit cause. A successful walk also sets the accessed flag in each entry it traversed and the dirty flag in the final entry on a write. These entries are written back to memory only when a flag actually changes, and the response is held until the last write has been acknowledged. A faulting walk leaves memory untouched. Switching address spaces needs nothing more than a new root value.

Entry format (32 bits): bits 31:12 frame number, bits 11:9 ignored by the walker, bit 0 present (P), bit 1 writable (W), bit 2 user-allowed (U), bits 3 and 4 cache attributes passed through untouched, bit 5 accessed (A), bit 6 dirty (D), bit 7 large-region (L), bit 8 reserved.

Top module: `xlate_walker`

## Requirements
- R1: The first-level entry is read at {root[31:12], va[31:22], 2'b00} and the second-level entry at {first_entry[31:12], va[21:12], 2'b00}; the low 12 bits of the root value are ignored.
- R2: For a 4 KB mapping the physical address is {second_entry[31:12], va[11:0]}, and a walk that needs no flag update performs exactly two memory reads and no write.
- R3: The present bit (bit 0) of each fetched entry is examined first; if it is 0 the walk ends with rsp_fault=1 and rsp_cause=1 (not-present) whatever the other bits hold, and no further entry is read.
- R4: A present first-level entry with L (bit 7) set ends the walk after one read with physical address {first_entry[31:22], va[21:0]}.
- R5: A write (req_write=1) through an entry whose W bit (bit 1) is 0, at either level, faults with rsp_cause=2 (write-protect).
- R6: A user access (req_user=1) through an entry whose U bit (bit 2) is 0, at either level, faults with rsp_cause=3 (user-protect); this check takes priority over R5, and supervisor accesses ignore U.
- R7: A successful walk sets A (bit 5) in every entry it traversed; D (bit 6) is set only in the final entry (second-level, or a first-level entry with L) and only on a write.
- R8: An entry is written back only when its A or D bit changes; a faulting walk performs no memory write.
- R9: The response is a single-cycle rsp_valid pulse issued only after the last write-back has been acknowledged; when both entries are written, the first-level entry goes first.
- R10: A value loaded with root_we is used by every request accepted after the load cycle.
- R11: The memory port keeps one access outstanding: once mem_req is raised, mem_req, mem_we, mem_addr and mem_wdata stay unchanged until mem_ack.
- R12: After reset req_ready=1, rsp_valid=0 and mem_req=0.
- R13: A request is accepted on a cycle with req_valid and req_ready high; req_ready stays low from then until the response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_we | input | 1 | Load the root-pointer register |
| root_wdata | input | 32 | New root value; bits 31:12 give the first-level table base |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user-mode access, 0 = supervisor |
| rsp_valid | output | 1 | One-cycle pulse carrying the result |
| rsp_fault | output | 1 | The walk ended in a fault |
| rsp_cause | output | 2 | 0 none, 1 not-present, 2 write-protect, 3 user-protect |
| rsp_paddr | output | 32 | Physical address when no fault |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for a write |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The hardest case to reach is a walk in which the first-level entry needs its accessed bit set but the second-level entry then faults: the directory update is already known yet must never reach memory. The bench prepares a directory entry with A clear in front of a second-level entry with P clear, counts memory writes at the port and reads the directory word back afterwards. The two-write sequence is reached by clearing A in both entries and inserting several cycles of memory latency, so that ordering and the hold-off of the response are exercised while the port is stalled.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;

   // Flag positions inside a translation entry.
   localparam int unsigned FLG_PRESENT = 0;
   localparam int unsigned FLG_WRITE   = 1;
   localparam int unsigned FLG_USER    = 2;
   localparam int unsigned FLG_ACCESS  = 5;
   localparam int unsigned FLG_DIRTY   = 6;
   localparam int unsigned FLG_LARGE   = 7;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_ABSENT = 2'd1,
      CAUSE_WPROT  = 2'd2,
      CAUSE_UPROT  = 2'd3
   } cause_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_RD,
      ST_LEAF_RD,
      ST_DIR_WB,
      ST_LEAF_WB,
      ST_DONE
   } walk_st_e;

endpackage

// File: rtl/xlate_perm_check.sv
`timescale 1ns/1ps
module xlate_perm_check
   import xlate_pkg::*;
(
   input  logic   ent_present,
   input  logic   ent_write,
   input  logic   ent_user,
   input  logic   is_write,
   input  logic   is_user,
   output logic   fault,
   output cause_e cause
);
   // Presence decides first; user protection outranks write protection.
   always_comb begin
      cause = CAUSE_NONE;
      if (!ent_present)
         cause = CAUSE_ABSENT;
      else if (is_user && !ent_user)
         cause = CAUSE_UPROT;
      else if (is_write && !ent_write)
         cause = CAUSE_WPROT;
      fault = (cause != CAUSE_NONE);
   end
endmodule

// File: rtl/xlate_flag_update.sv
`timescale 1ns/1ps
module xlate_flag_update
   import xlate_pkg::*;
#(
   parameter int unsigned ENT_W     = 32,
   parameter bit          UPDATE_EN = 1'b1
) (
   input  logic [ENT_W-1:0] ent,
   input  logic             set_dirty,
   output logic [ENT_W-1:0] ent_new,
   output logic             changed
);
   generate
      if (UPDATE_EN) begin : g_update
         always_comb begin
            ent_new             = ent;
            ent_new[FLG_ACCESS] = 1'b1;
            if (set_dirty)
               ent_new[FLG_DIRTY] = 1'b1;
            changed = (ent_new != ent);
         end
      end else begin : g_frozen
         logic unused_dirty;
         assign unused_dirty = set_dirty;
         assign ent_new      = ent;
         assign changed      = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/xlate_addr_gen.sv
`timescale 1ns/1ps
module xlate_addr_gen #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned OFF_W    = 12,
   parameter bit          LARGE_EN = 1'b1
) (
   input  logic [ADDR_W-OFF_W-1:0] root_frame,
   input  logic [ADDR_W-OFF_W-1:0] ent_frame,
   input  logic                    ent_large,
   input  logic [ADDR_W-1:0]       va,
   output logic [ADDR_W-1:0]       dir_addr,
   output logic [ADDR_W-1:0]       leaf_addr,
   output logic [ADDR_W-1:0]       paddr_small,
   output logic [ADDR_W-1:0]       paddr_large,
   output logic                    is_large
);
   localparam int unsigned SHIFT   = $clog2(ADDR_W / 8);
   localparam int unsigned BIG_W   = OFF_W + IDX_W;
   localparam int unsigned L1_LSB  = BIG_W;
   localparam int unsigned L2_LSB  = OFF_W;

   logic [IDX_W-1:0] l1_idx;
   logic [IDX_W-1:0] l2_idx;

   assign l1_idx      = va[L1_LSB +: IDX_W];
   assign l2_idx      = va[L2_LSB +: IDX_W];
   assign dir_addr    = {root_frame, l1_idx, {SHIFT{1'b0}}};
   assign leaf_addr   = {ent_frame, l2_idx, {SHIFT{1'b0}}};
   assign paddr_small = {ent_frame, va[OFF_W-1:0]};

   generate
      if (LARGE_EN) begin : g_large
         assign is_large    = ent_large;
         assign paddr_large = {ent_frame[ADDR_W-OFF_W-1 -: ADDR_W-BIG_W], va[BIG_W-1:0]};
      end else begin : g_small_only
         logic unused_large;
         assign unused_large = ent_large;
         assign is_large     = 1'b0;
         assign paddr_large  = paddr_small;
      end
   endgenerate
endmodule

// File: rtl/xlate_walker.sv
`timescale 1ns/1ps
module xlate_walker
   import xlate_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned IDX_W     = 10,
   parameter int unsigned OFF_W     = 12,
   parameter bit          LARGE_EN  = 1'b1,
   parameter bit          UPDATE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              root_we,
   input  logic [ADDR_W-1:0] root_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic              req_write,
   input  logic              req_user,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [1:0]        rsp_cause,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata
);
   localparam int unsigned FRAME_W = ADDR_W - OFF_W;
   localparam int unsigned SHIFT   = $clog2(ADDR_W / 8);

   // Elaboration-time parameter checks.
   if (ADDR_W != 2 * IDX_W + OFF_W) begin : g_bad_split
      $error("xlate_walker: ADDR_W must equal two indices plus the offset");
   end
   if (IDX_W + SHIFT != OFF_W) begin : g_bad_table
      $error("xlate_walker: one table must fill exactly one page");
   end
   if (OFF_W <= FLG_LARGE + 1) begin : g_bad_flags
      $error("xlate_walker: offset too narrow for the entry flags");
   end

   walk_st_e          st_q;
   logic [FRAME_W-1:0] root_q;
   logic [ADDR_W-1:0] va_q;
   logic              wr_q;
   logic              usr_q;
   logic [ADDR_W-1:0] dir_addr_q;
   logic [ADDR_W-1:0] leaf_addr_q;
   logic [ADDR_W-1:0] dir_new_q;
   logic [ADDR_W-1:0] leaf_new_q;
   logic              dir_wb_q;
   logic              leaf_wb_q;
   logic [ADDR_W-1:0] paddr_q;
   logic              fault_q;
   cause_e            cause_q;

   logic [ADDR_W-1:0] va_sel;
   logic [ADDR_W-1:0] gen_dir_addr;
   logic [ADDR_W-1:0] gen_leaf_addr;
   logic [ADDR_W-1:0] gen_paddr_small;
   logic [ADDR_W-1:0] gen_paddr_large;
   logic              gen_is_large;
   logic              chk_fault;
   cause_e            chk_cause;
   logic [ADDR_W-1:0] upd_ent;
   logic              upd_chg;
   logic              upd_dirty;
   logic              take_ack;

   logic unused_root_low;
   assign unused_root_low = &{1'b0, root_wdata[OFF_W-1:0]};

   assign va_sel    = (st_q == ST_IDLE) ? req_vaddr : va_q;
   assign upd_dirty = wr_q && ((st_q == ST_LEAF_RD) || gen_is_large);
   assign take_ack  = mem_req && mem_ack;

   xlate_addr_gen #(
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W),
      .OFF_W   (OFF_W),
      .LARGE_EN(LARGE_EN)
   ) u_addr (
      .root_frame (root_q),
      .ent_frame  (mem_rdata[ADDR_W-1:OFF_W]),
      .ent_large  (mem_rdata[FLG_LARGE]),
      .va         (va_sel),
      .dir_addr   (gen_dir_addr),
      .leaf_addr  (gen_leaf_addr),
      .paddr_small(gen_paddr_small),
      .paddr_large(gen_paddr_large),
      .is_large   (gen_is_large)
   );

   xlate_perm_check u_perm (
      .ent_present(mem_rdata[FLG_PRESENT]),
      .ent_write  (mem_rdata[FLG_WRITE]),
      .ent_user   (mem_rdata[FLG_USER]),
      .is_write   (wr_q),
      .is_user    (usr_q),
      .fault      (chk_fault),
      .cause      (chk_cause)
   );

   xlate_flag_update #(
      .ENT_W    (ADDR_W),
      .UPDATE_EN(UPDATE_EN)
   ) u_upd (
      .ent      (mem_rdata),
      .set_dirty(upd_dirty),
      .ent_new  (upd_ent),
      .changed  (upd_chg)
   );

   // Root pointer register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         root_q <= '0;
      else if (root_we)
         root_q <= root_wdata[ADDR_W-1:OFF_W];
   end

   // Walk sequencer.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         va_q        <= '0;
         wr_q        <= 1'b0;
         usr_q       <= 1'b0;
         dir_addr_q  <= '0;
         leaf_addr_q <= '0;
         dir_new_q   <= '0;
         leaf_new_q  <= '0;
         dir_wb_q    <= 1'b0;
         leaf_wb_q   <= 1'b0;
         paddr_q     <= '0;
         fault_q     <= 1'b0;
         cause_q     <= CAUSE_NONE;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q       <= req_vaddr;
                  wr_q       <= req_write;
                  usr_q      <= req_user;
                  dir_addr_q <= gen_dir_addr;
                  dir_wb_q   <= 1'b0;
                  leaf_wb_q  <= 1'b0;
                  paddr_q    <= '0;
                  fault_q    <= 1'b0;
                  cause_q    <= CAUSE_NONE;
                  st_q       <= ST_DIR_RD;
               end
            end
            ST_DIR_RD: begin
               if (take_ack) begin
                  if (chk_fault) begin
                     fault_q <= 1'b1;
                     cause_q <= chk_cause;
                     st_q    <= ST_DONE;
                  end else begin
                     dir_new_q <= upd_ent;
                     dir_wb_q  <= upd_chg;
                     if (gen_is_large) begin
                        paddr_q <= gen_paddr_large;
                        st_q    <= upd_chg ? ST_DIR_WB : ST_DONE;
                     end else begin
                        leaf_addr_q <= gen_leaf_addr;
                        st_q        <= ST_LEAF_RD;
                     end
                  end
               end
            end
            ST_LEAF_RD: begin
               if (take_ack) begin
                  if (chk_fault) begin
                     fault_q  <= 1'b1;
                     cause_q  <= chk_cause;
                     dir_wb_q <= 1'b0;
                     st_q     <= ST_DONE;
                  end else begin
                     paddr_q    <= gen_paddr_small;
                     leaf_new_q <= upd_ent;
                     leaf_wb_q  <= upd_chg;
                     if (dir_wb_q)
                        st_q <= ST_DIR_WB;
                     else if (upd_chg)
                        st_q <= ST_LEAF_WB;
                     else
                        st_q <= ST_DONE;
                  end
               end
            end
            ST_DIR_WB: begin
               if (take_ack)
                  st_q <= leaf_wb_q ? ST_LEAF_WB : ST_DONE;
            end
            ST_LEAF_WB: begin
               if (take_ack)
                  st_q <= ST_DONE;
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // Port drive.
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (st_q)
         ST_DIR_RD: begin
            mem_req  = 1'b1;
            mem_addr = dir_addr_q;
         end
         ST_LEAF_RD: begin
            mem_req  = 1'b1;
            mem_addr = leaf_addr_q;
         end
         ST_DIR_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dir_addr_q;
            mem_wdata = dir_new_q;
         end
         ST_LEAF_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = leaf_addr_q;
            mem_wdata = leaf_new_q;
         end
         default: ;
      endcase
   end

   assign req_ready = (st_q == ST_IDLE);
   assign rsp_valid = (st_q == ST_DONE);
   assign rsp_fault = fault_q;
   assign rsp_cause = cause_q;
   assign rsp_paddr = paddr_q;

endmodule

// File: rtl/xlate_walker_chk.sv
`timescale 1ns/1ps
module xlate_walker_chk
   import xlate_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_fault,
   input logic [1:0]        rsp_cause,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] mem_wdata,
   input logic              mem_ack
);
   logic [1:0] reads_q;
   logic       wrote_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reads_q <= '0;
         wrote_q <= 1'b0;
      end else if (req_valid && req_ready) begin
         reads_q <= '0;
         wrote_q <= 1'b0;
      end else if (mem_req && mem_ack) begin
         if (mem_we)
            wrote_q <= 1'b1;
         else if (reads_q != 2'd3)
            reads_q <= reads_q + 2'd1;
      end
   end

   p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

   p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req && !rsp_valid);

   p_accept_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   p_fault_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> !wrote_q);

   p_cause_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

   p_wb_accessed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[FLG_ACCESS]);

   p_two_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> reads_q < 2'd2);

endmodule

bind xlate_walker xlate_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .rsp_valid(rsp_valid),
   .rsp_fault(rsp_fault),
   .rsp_cause(rsp_cause),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .mem_ack  (mem_ack)
);

// File: tb/xlate_walker_bench.sv
`timescale 1ns/1ps
module xlate_walker_bench;

   localparam logic [31:0] FP = 32'h1, FW = 32'h2, FU = 32'h4;
   localparam logic [31:0] FA = 32'h20, FD = 32'h40, FL = 32'h80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        root_we = 1'b0;
   logic [31:0] root_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [1:0]  rsp_cause;
   logic [31:0] rsp_paddr;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #5 clk = ~clk;

   xlate_walker u_xlate_walker (
      .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user), .rsp_valid(rsp_valid),
      .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int n_checks = 0;
   int n_errors = 0;

   logic [31:0] mem [0:4095];
   int          lat = 0;
   int          wait_cnt = 0;
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   int          stab_err = 0;
   logic [31:0] held_addr = '0;
   logic [31:0] rd_log [0:3];
   logic [31:0] wr_log [0:3];

   logic [31:0] r_paddr;
   logic        r_fault;
   logic [1:0]  r_cause;
   int          r_wr_at_rsp;

   function automatic logic [31:0] mk(input logic [19:0] frame, input logic [31:0] flags);
      return {frame, 12'h000} | flags;
   endfunction

   // Memory responder, acting at the falling edge.
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         if (wait_cnt == 0)
            held_addr = mem_addr;
         else if (mem_addr !== held_addr)
            stab_err++;
         if (wait_cnt >= lat) begin
            wait_cnt = 0;
            mem_ack  = 1'b1;
            if (mem_we) begin
               mem[mem_addr[13:2]] = mem_wdata;
               if (wr_cnt < 4) wr_log[wr_cnt] = mem_addr;
               wr_cnt++;
            end else begin
               mem_rdata = mem[mem_addr[13:2]];
               if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
               rd_cnt++;
            end
         end else begin
            wait_cnt++;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_root(input logic [31:0] v);
      @(negedge clk);
      root_we    = 1'b1;
      root_wdata = v;
      @(negedge clk);
      root_we    = 1'b0;
   endtask

   task automatic walk(input logic [31:0] va, input logic wr, input logic usr);
      int n;
      @(negedge clk);
      rd_cnt    = 0;
      wr_cnt    = 0;
      req_valid = 1'b1;
      req_vaddr = va;
      req_write = wr;
      req_user  = usr;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check("R13 busy after accept", {31'b0, req_ready}, 32'd0);
      n = 0;
      while (!rsp_valid && n < 500) begin
         @(negedge clk);
         n++;
      end
      check("R9 response arrives", {31'b0, rsp_valid}, 32'd1);
      r_paddr     = rsp_paddr;
      r_fault     = rsp_fault;
      r_cause     = rsp_cause;
      r_wr_at_rsp = wr_cnt;
      @(negedge clk);
      check("R9 single-cycle response", {31'b0, rsp_valid}, 32'd0);
   endtask

   task automatic t_reset;
      check("R12 req_ready after reset", {31'b0, req_ready}, 32'd1);
      check("R12 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
      check("R12 mem_req after reset", {31'b0, mem_req}, 32'd0);
   endtask

   task automatic t_basic_read;
      lat = 0;
      mem[12'h403] = mk(20'h00002, FP | FW | FU | FA);
      mem[12'h805] = mk(20'h12345, FP | FW | FU | FA);
      walk(32'h00C05ABC, 1'b0, 1'b1);
      check("R2 paddr", r_paddr, 32'h12345ABC);
      check("R2 no fault", {31'b0, r_fault}, 32'd0);
      check("R2 two reads", rd_cnt, 32'd2);
      check("R8 no write when flags set", wr_cnt, 32'd0);
      check("R1 first entry address", rd_log[0], 32'h0000100C);
      check("R1 second entry address", rd_log[1], 32'h00002014);
   endtask

   task automatic t_access_update;
      logic [31:0] d0, l0;
      lat = 3;
      d0 = mk(20'h00002, FP | FW | FU);
      l0 = mk(20'h0ABCD, FP | FW | FU);
      mem[12'h404] = d0;
      mem[12'h806] = l0;
      walk(32'h01006010, 1'b0, 1'b0);
      check("R7 paddr", r_paddr, 32'h0ABCD010);
      check("R9 writes before response", r_wr_at_rsp, 32'd2);
      check("R9 first write is directory", wr_log[0], 32'h00001010);
      check("R9 second write is leaf", wr_log[1], 32'h00002018);
      check("R7 directory A set", mem[12'h404], d0 | FA);
      check("R7 leaf A set, no D on read", mem[12'h806], l0 | FA);
   endtask

   task automatic t_dirty;
      logic [31:0] l0, d0;
      lat = 1;
      d0 = mem[12'h404];
      l0 = mk(20'h00777, FP | FW | FA);
      mem[12'h807] = l0;
      walk(32'h01007FFF, 1'b1, 1'b0);
      check("R7 write paddr", r_paddr, 32'h00777FFF);
      check("R8 one write", wr_cnt, 32'd1);
      check("R7 leaf D set", mem[12'h807], l0 | FD);
      check("R7 directory keeps no D", mem[12'h404], d0);
      walk(32'h01007FFF, 1'b1, 1'b0);
      check("R8 repeat write no update", wr_cnt, 32'd0);
   endtask

   task automatic t_absent;
      logic [31:0] d0;
      lat = 2;
      mem[12'h408] = 32'hFFFF_FFFE;
      walk(32'h02000123, 1'b1, 1'b1);
      check("R3 L1 absent fault", {31'b0, r_fault}, 32'd1);
      check("R3 L1 absent cause", {30'b0, r_cause}, 32'd1);
      check("R3 L1 absent one read", rd_cnt, 32'd1);
      check("R8 L1 absent no write", wr_cnt, 32'd0);
      d0 = mk(20'h00002, FP | FW | FU);
      mem[12'h409] = d0;
      mem[12'h809] = mk(20'h55555, FW | FU | FA);
      walk(32'h02409000, 1'b0, 1'b0);
      check("R3 L2 absent cause", {30'b0, r_cause}, 32'd1);
      check("R3 L2 absent reads", rd_cnt, 32'd2);
      check("R8 L2 absent no write", wr_cnt, 32'd0);
      check("R8 directory A untouched", mem[12'h409], d0);
   endtask

   task automatic t_wprot;
      lat = 0;
      mem[12'h80A] = mk(20'h11111, FP | FU | FA);
      walk(32'h0100A004, 1'b1, 1'b1);
      check("R5 leaf write-protect", {30'b0, r_cause}, 32'd2);
      check("R8 write-protect no write", wr_cnt, 32'd0);
      walk(32'h0100A004, 1'b0, 1'b1);
      check("R5 read through W=0", {r_fault, r_paddr[30:0]}, 32'h11111004 & 32'h7FFFFFFF);
      mem[12'h40C] = mk(20'h00002, FP | FU | FA);
      walk(32'h0300A000, 1'b1, 1'b0);
      check("R5 directory write-protect", {30'b0, r_cause}, 32'd2);
      check("R5 directory fault one read", rd_cnt, 32'd1);
   endtask

   task automatic t_uprot;
      lat = 1;
      mem[12'h80B] = mk(20'h22222, FP | FA);
      walk(32'h0100B000, 1'b1, 1'b1);
      check("R6 user-protect before write", {30'b0, r_cause}, 32'd3);
      walk(32'h0100B000, 1'b0, 1'b0);
      check("R6 supervisor ignores U", {31'b0, r_fault}, 32'd0);
      check("R6 supervisor paddr", r_paddr, 32'h22222000);
      mem[12'h40D] = mk(20'h00002, FP | FW | FA);
      walk(32'h0340B000, 1'b0, 1'b1);
      check("R6 directory user-protect", {30'b0, r_cause}, 32'd3);
   endtask

   task automatic t_large;
      logic [31:0] e0;
      lat = 2;
      e0 = 32'hABC55000 | FP | FW | FU | FL;
      mem[12'h500] = e0;
      walk(32'h40012345, 1'b1, 1'b1);
      check("R4 large paddr", r_paddr, 32'hABC12345);
      check("R4 large one read", rd_cnt, 32'd1);
      check("R4 large entry address", rd_log[0], 32'h00001400);
      check("R7 large A and D", mem[12'h500], e0 | FA | FD);
   endtask

   task automatic t_root_reload;
      lat = 0;
      mem[12'hC03] = mk(20'h00000, FP | FW | FU | FA);
      mem[12'h005] = mk(20'h0BEEF, FP | FW | FU | FA);
      set_root(32'h00003FFF);
      walk(32'h00C05ABC, 1'b0, 1'b1);
      check("R10 new root paddr", r_paddr, 32'h0BEEFABC);
      check("R10 new root entry address", rd_log[0], 32'h0000300C);
      check("R1 second-level from frame 0", rd_log[1], 32'h00000014);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      for (int i = 0; i < 4; i++) begin
         rd_log[i] = '0;
         wr_log[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      set_root(32'h00001ABC);
      t_basic_read();
      t_access_update();
      t_dirty();
      t_absent();
      t_wprot();
      t_uprot();
      t_large();
      t_root_reload();
      check("R11 address held while stalled", stab_err, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule